// File: doc/BRIEF.md
# Memory Self-Test Control and Status Register

This block is a two-bit serial test data register that sits between a scan path and a memory self-test engine. Two static control levels go to the engine, a start request and a clear request. Two static status levels come back from it, a completion flag and an error flag. Each of the two bits has its own shift stage and its own update latch. The latches hold the control levels steady. The shift stages are loaded either from the scan path or from the engine's status pins.

Software starts an engine by shifting the two control bits in and pulsing update. It polls the engine by pulsing capture and shifting the two bits out. Several of these registers can be chained serially. Each one acts only while its local select is high. While the select is low, the register passes its serial input straight to its serial output and leaves its own state unchanged.

Top module: `mbist_tdr`

## Requirements
- R1: While `trst_n` is low, both update latches and both shift stages are cleared, so `bist_invoke` and `bist_reset` are 0.
- R2: With `sel` and `shift_en` high and `capture_en` low, each rising `tck` moves `si` into bit 1 and bit 1 into bit 0. `so` shows bit 0, so the first bit shifted in ends up in bit 0 after two shifts.
- R3: With `sel` and `capture_en` high, a rising `tck` loads `bist_done` into bit 0 and `bist_fail` into bit 1. Capture takes priority over a shift strobe that is high in the same cycle.
- R4: With `sel` and `update_en` high, a rising `tck` copies bit 0 into the latch that drives `bist_invoke` and bit 1 into the latch that drives `bist_reset`.
- R5: Outside an update, the two latches keep their value, including during shift and capture.
- R6: While `sel` is low, the shift stages and latches do not change whatever the strobes do, and `so` equals `si`.
- R7: A poll (one capture, then two shifts) presents `bist_done` at `so` first and then `bist_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| sel | input | 1 | Local select for this register |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| bist_done | input | 1 | Engine completion level |
| bist_fail | input | 1 | Engine error level |
| bist_invoke | output | 1 | Start level to the engine |
| bist_reset | output | 1 | Clear level to the engine |

## Verification
The hardest case to reach is a status word with the error flag set and completion asserted. That value only exists after the engine has been started and left running for its full latency. The bench drives a behavioural engine model whose error outcome is selectable. It shifts in a start request, updates, waits out the model's latency, and then polls. The same state is reused to show that capture wins over a coincident shift, and that a deselected register neither captures nor updates while its strobes toggle.

// File: rtl/mbtdr_pkg.sv
package mbtdr_pkg;
   localparam int TDR_BITS   = 2;
   localparam int IDX_INVOKE = 0;  // update side of bit 0 (nearest so)
   localparam int IDX_RESET  = 1;  // update side of bit 1
   localparam int IDX_DONE   = 0;  // capture side of bit 0
   localparam int IDX_FAIL   = 1;  // capture side of bit 1

   typedef struct packed {
      logic cap;
      logic shf;
      logic upd;
   } tdr_ops_t;
endpackage

// File: rtl/mbtdr_ctrl.sv
module mbtdr_ctrl
   import mbtdr_pkg::*;
(
   input  logic     sel,
   input  logic     capture_en,
   input  logic     shift_en,
   input  logic     update_en,
   output tdr_ops_t ops
);
   always_comb begin
      ops.cap = sel & capture_en;
      ops.shf = sel & shift_en & ~capture_en;
      ops.upd = sel & update_en;
   end
endmodule

// File: rtl/mbtdr_cell.sv
module mbtdr_cell #(
   parameter logic RESET_VAL = 1'b0
)(
   input  logic tck,
   input  logic trst_n,
   input  logic en_cap,
   input  logic en_shf,
   input  logic en_upd,
   input  logic cap_in,
   input  logic shf_in,
   output logic shf_q,
   output logic upd_q
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      shf_q <= 1'b0;
      else if (en_cap)  shf_q <= cap_in;
      else if (en_shf)  shf_q <= shf_in;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      upd_q <= RESET_VAL;
      else if (en_upd)  upd_q <= shf_q;
   end

   // R4
   upd_copy_chk: assert property (@(posedge tck) disable iff (!trst_n)
      en_upd |=> upd_q == $past(shf_q));
   // R5
   upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !en_upd |=> $stable(upd_q));
endmodule

// File: rtl/mbist_tdr.sv
module mbist_tdr
   import mbtdr_pkg::*;
#(
   parameter int   NUM_CELLS   = TDR_BITS,
   parameter bit   IDLE_BYPASS = 1'b1,
   parameter logic [NUM_CELLS-1:0] UPD_RESET = '0
)(
   input  logic tck,
   input  logic trst_n,
   input  logic sel,
   input  logic capture_en,
   input  logic shift_en,
   input  logic update_en,
   input  logic si,
   output logic so,
   input  logic bist_done,
   input  logic bist_fail,
   output logic bist_invoke,
   output logic bist_reset
);
   localparam int MSB = NUM_CELLS - 1;

   initial begin
      cells_chk: assert (NUM_CELLS == TDR_BITS)
         else $error("register must be exactly %0d cells", TDR_BITS);
      rstval_chk: assert (UPD_RESET == '0)
         else $error("update latches must clear to deasserted levels");
   end

   tdr_ops_t           ops;
   logic [MSB:0]       stage;
   logic [MSB:0]       upd;
   logic [MSB:0]       status;

   always_comb begin
      status           = '0;
      status[IDX_DONE] = bist_done;
      status[IDX_FAIL] = bist_fail;
   end

   mbtdr_ctrl u_ctrl (
      .sel        (sel),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .ops        (ops)
   );

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic feed;
      if (i == MSB) begin : g_head
         assign feed = si;
      end else begin : g_body
         assign feed = stage[i+1];
      end
      mbtdr_cell #(.RESET_VAL(UPD_RESET[i])) u_cell (
         .tck    (tck),
         .trst_n (trst_n),
         .en_cap (ops.cap),
         .en_shf (ops.shf),
         .en_upd (ops.upd),
         .cap_in (status[i]),
         .shf_in (feed),
         .shf_q  (stage[i]),
         .upd_q  (upd[i])
      );
   end

   if (IDLE_BYPASS) begin : g_bypass
      assign so = sel ? stage[0] : si;
   end else begin : g_direct
      assign so = stage[0];
   end

   assign bist_invoke = upd[IDX_INVOKE];
   assign bist_reset  = upd[IDX_RESET];

   // R1
   rst_clear_chk: assert property (@(posedge tck)
      !trst_n |-> (!bist_invoke && !bist_reset && stage == '0));
   // R3
   cap_done_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && capture_en) |=> stage[IDX_DONE] == $past(bist_done));
   // R3
   cap_fail_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && capture_en) |=> stage[IDX_FAIL] == $past(bist_fail));
   // R2
   shift_in_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && shift_en && !capture_en) |=> stage[MSB] == $past(si));
   // R6
   idle_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !sel |=> ($stable(stage) && $stable(upd)));
endmodule

// File: tb/mbist_tdr_bench.sv
module mbist_tdr_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DONE_LAT   = 5;
   localparam int WDOG_LIM   = 20000;

   logic tck = 0, trst_n = 0, sel = 0;
   logic capture_en = 0, shift_en = 0, update_en = 0, si = 0;
   logic so, bist_invoke, bist_reset;
   logic bist_done = 0, bist_fail = 0, fail_mode = 0;
   int   lat_cnt = 0, n_chk = 0, n_err = 0, cyc = 0;
   logic [1:0] rd;

   always #(CLK_PERIOD/2) tck = ~tck;

   mbist_tdr u_mbist_tdr (
      .tck(tck), .trst_n(trst_n), .sel(sel), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .si(si), .so(so),
      .bist_done(bist_done), .bist_fail(bist_fail),
      .bist_invoke(bist_invoke), .bist_reset(bist_reset)
   );

   // behavioural self-test engine model
   always @(posedge tck) begin
      if (bist_reset) begin
         bist_done <= 0; bist_fail <= 0; lat_cnt <= 0;
      end else if (bist_invoke && !bist_done) begin
         if (lat_cnt == DONE_LAT-1) begin
            bist_done <= 1; bist_fail <= fail_mode;
         end else lat_cnt <= lat_cnt + 1;
      end
   end

   always @(posedge tck) begin
      cyc <= cyc + 1;
      if (cyc == WDOG_LIM) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got cycle %0d expected under %0d", cyc, WDOG_LIM);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // shift din in (din[0] first); dout returns the bits seen at so, in order
   task automatic do_shift(input logic [1:0] din, output logic [1:0] dout);
      for (int i = 0; i < 2; i++) begin
         @(negedge tck); sel = 1; shift_en = 1; si = din[i];
         #1 dout[i] = so;
      end
      @(negedge tck); shift_en = 0;
   endtask

   task automatic pulse_update();
      @(negedge tck); sel = 1; update_en = 1;
      @(negedge tck); update_en = 0;
      #1;
   endtask

   task automatic pulse_capture();
      @(negedge tck); sel = 1; capture_en = 1;
      @(negedge tck); capture_en = 0;
   endtask

   task automatic t_reset();
      #1 chk("R1 latches in reset", {bist_reset, bist_invoke}, 2'b00);
      @(negedge tck); trst_n = 1;
      do_shift(2'b00, rd);
      chk("R1 stages cleared", rd, 2'b00);
   endtask

   task automatic t_shift_order();
      do_shift(2'b10, rd);
      do_shift(2'b01, rd);
      chk("R2 shift order", rd, 2'b10);
      chk("R5 no update during shift", {bist_reset, bist_invoke}, 2'b00);
   endtask

   task automatic t_invoke_pass();
      fail_mode = 0;
      do_shift(2'b01, rd);
      pulse_update();
      chk("R4 invoke set", {bist_reset, bist_invoke}, 2'b01);
      repeat (DONE_LAT + 3) @(negedge tck);
      pulse_capture();
      chk("R5 hold during capture", {bist_reset, bist_invoke}, 2'b01);
      do_shift(2'b01, rd);
      chk("R7 poll done/no fail", rd, 2'b01);
      chk("R5 hold during shift", {bist_reset, bist_invoke}, 2'b01);
   endtask

   task automatic t_invoke_fail();
      do_shift(2'b10, rd);
      pulse_update();
      chk("R4 reset set", {bist_reset, bist_invoke}, 2'b10);
      repeat (2) @(negedge tck);
      pulse_capture();
      do_shift(2'b00, rd);
      chk("R3 cleared status", rd, 2'b00);
      fail_mode = 1;
      do_shift(2'b01, rd);
      pulse_update();
      chk("R4 invoke again", {bist_reset, bist_invoke}, 2'b01);
      repeat (DONE_LAT + 3) @(negedge tck);
      pulse_capture();
      do_shift(2'b10, rd);
      chk("R3 R7 poll done+fail", rd, 2'b11);
   endtask

   task automatic t_deselect();
      logic [1:0] sv;
      for (int i = 0; i < 6; i++) begin
         @(negedge tck); sel = 0; si = i[0];
         capture_en = (i == 1); shift_en = 1; update_en = (i > 2);
         #1 sv = {1'b0, so};
         chk("R6 bypass so", sv, {1'b0, si});
      end
      @(negedge tck); capture_en = 0; shift_en = 0; update_en = 0;
      #1 chk("R6 latches held", {bist_reset, bist_invoke}, 2'b01);
      do_shift(2'b11, rd);
      chk("R6 stages held", rd, 2'b10);
   endtask

   task automatic t_cap_priority();
      @(negedge tck); sel = 1; capture_en = 1; shift_en = 1; si = 0;
      @(negedge tck); capture_en = 0; shift_en = 0;
      do_shift(2'b00, rd);
      chk("R3 capture over shift", rd, 2'b11);
   endtask

   task automatic t_trst();
      do_shift(2'b11, rd);
      @(negedge tck); trst_n = 0;
      #1 chk("R1 async clear", {bist_reset, bist_invoke}, 2'b00);
      @(negedge tck); trst_n = 1;
      do_shift(2'b00, rd);
      chk("R1 stages after reset", rd, 2'b00);
   endtask

   initial begin
      t_reset();
      t_shift_order();
      t_invoke_pass();
      t_invoke_fail();
      t_deselect();
      t_cap_priority();
      t_trst();
      repeat (2) @(negedge tck);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule